// File: doc/BRIEF.md
# Power-Up Sequencer

This controller brings a chip from its off state to running and back. While off, every core rail enable is low, the core reset is held and only the always-on timing domain is active. Three wake sources are watched: a power-switch level, an external 5 V valid level and a one-cycle real-time-clock alarm pulse. The two level sources must stay high without a break for a programmable number of slow ticks (100 ticks of a 1 ms tick by default) before they count. The alarm pulse takes effect at once.

On a wake event the controller selects a supply path. The linear-regulator path is used when the external 5 V input is high at that moment; otherwise the switching-converter path is used. It then enables the digital, analog and I/O rails together. The core reset is released only after all three rail-good flags, passed through a two-flop synchronizer, are high. A start-up returns to off if its trigger level drops or a tick-counted timeout expires before the rails are good. A power-down request from the running state asserts reset first and removes the rails one cycle later. When the auto-restart input is set, this is followed by a fresh start-up that needs no wake event.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During and right after reset, state_o is 0, wake_src_o is 0, rail_en_o is 3'b000, core_rst_n_o is 0 and both path outputs are 0.
- R2: A power-switch level that goes high moves state_o from 0 to 1 (qualify) one cycle later. It starts a power-up only after HOLD_TICKS ticks seen while it stays high. If it drops earlier, the controller returns to state_o 0 without enabling rails.
- R3: The 5 V level qualifies under the same hold rule as R2, and a power-up it starts reports wake_src_o = 2.
- R4: An alarm pulse in the off or qualify state moves the controller to ramp (state_o 2) on the next cycle, with no hold, and sets wake_src_o = 3.
- R5: On entering ramp, path_lin_o is 1 if the 5 V input was high, and path_dcdc_o is 1 otherwise. Exactly one of the two is high while the rails are enabled, and both are 0 when they are not.
- R6: In ramp all three rail_en_o bits are 1 and core_rst_n_o is 0. The run state (state_o 3, core_rst_n_o 1) is entered 3 cycles after rail_good_i becomes 3'b111. Any other rail_good_i pattern keeps the ramp state.
- R7: A ramp started by the power switch aborts to off on the cycle after that switch drops. A ramp started by 5 V aborts on the cycle after 5 V drops. The other level, and both levels in the run state, have no effect.
- R8: A ramp whose rails are not all good after RAMP_TIMEOUT_TICKS ticks returns to off on the edge that sees the last of those ticks.
- R9: A power-down request in run drives core_rst_n_o low on the next cycle with the rails still on (state_o stays 3), and clears rail_en_o one cycle after that.
- R10: With auto_restart_i high at power-down, the controller spends one cycle off and then enters ramp with wake_src_o = 0. An abort or timeout never triggers a restart.
- R11: When several wake sources become valid on the same cycle, the alarm wins over the power switch, and the power switch wins over 5 V (wake_src_o = 1 for the power switch).
- R12: state_o encodes off = 0, qualify = 1, ramp = 2, run = 3, and run is only ever entered from ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle slow time-base pulse |
| pswitch_i | input | 1 | Power-switch above its qualifying level |
| vbus_ok_i | input | 1 | External 5 V valid |
| rtc_alarm_i | input | 1 | Real-time-clock alarm pulse |
| auto_restart_i | input | 1 | Restart after power-down |
| pwr_down_req_i | input | 1 | Request to leave run |
| rail_good_i | input | 3 | Rail-good flags {io, analog, digital}, asynchronous |
| rail_en_o | output | 3 | Rail enables {io, analog, digital} |
| path_lin_o | output | 1 | Linear-regulator path selected |
| path_dcdc_o | output | 1 | Switching-converter path selected |
| core_rst_n_o | output | 1 | Core reset, active low |
| state_o | output | 2 | Sequencer state code |
| wake_src_o | output | 2 | Cause of last power-up (0 restart/none, 1 switch, 2 5 V, 3 alarm) |

## Verification
The hardest case to reach is a tie between wake sources. The alarm must arrive on exactly the cycle the power-switch hold counter completes. The bench delivers the final tick on its own, then raises the alarm on the next cycle, when the completed count first shows as a qualification. The hold rules get a full sweep, and every partial rail-good pattern is held in ramp before a timeout is forced.

// File: rtl/pwr_seq_pkg.sv
// Shared types for the power-up sequencer.
// Assumes: three core rails; state codes visible at the top are 2 bits.
package pwr_seq_pkg;

    localparam int RAIL_COUNT = 3;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_QUAL = 3'd1,
        ST_RAMP = 3'd2,
        ST_RUN  = 3'd3,
        ST_DOWN = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PSW  = 2'd1,
        SRC_VBUS = 2'd2,
        SRC_RTC  = 2'd3
    } wake_src_e;

endpackage

// File: rtl/pwr_hold_qual.sv
// Hold qualifier: asserts qual_o while in_i has stayed high for HOLD_TICKS ticks.
// Assumes tick_i is a one-cycle pulse; any low cycle on in_i restarts the count.
module pwr_hold_qual #(
    parameter int HOLD_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic in_i,
    output logic qual_o
);
    localparam int CNT_W = $clog2(HOLD_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_TICKS);

    logic [CNT_W-1:0] cnt_q;

    // Count ticks while the input is high, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Qualified only while the input is still high.
    assign qual_o = in_i && (cnt_q == CNT_MAX);

endmodule

// File: rtl/pwr_bit_sync.sv
// Multi-flop synchronizer for a vector of independent level signals.
// Assumes each bit is a slow level; no bus coherency is given.
module pwr_bit_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift one stage of the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= (s == 0) ? d_i : stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_fsm.sv
// Sequencer state machine: wake handling, path choice, ramp abort/timeout,
// power-down teardown and auto-restart.
// Assumes qualified wake inputs and synchronized rail-good come from siblings.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int RAMP_TIMEOUT_TICKS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       psw_raw_i,
    input  logic       vbus_raw_i,
    input  logic       psw_qual_i,
    input  logic       vbus_qual_i,
    input  logic       rtc_i,
    input  logic       rails_good_i,
    input  logic       pdn_req_i,
    input  logic       auto_restart_i,
    output seq_state_e state_o,
    output wake_src_e  src_o,
    output logic       lin_o
);
    localparam int TO_W = $clog2(RAMP_TIMEOUT_TICKS + 1);
    localparam logic [TO_W-1:0] TO_LAST = TO_W'(RAMP_TIMEOUT_TICKS - 1);

    seq_state_e      state_q, state_d;
    wake_src_e       src_q, src_d;
    logic            lin_q, lin_d;
    logic            pend_q, pend_d;
    logic [TO_W-1:0] to_q, to_d;
    logic            trig_lost;

    // Loss of the level that started the current ramp.
    always_comb begin
        trig_lost = ((src_q == SRC_PSW) && !psw_raw_i) ||
                    ((src_q == SRC_VBUS) && !vbus_raw_i);
    end

    // Next-state and next-register logic.
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        lin_d   = lin_q;
        pend_d  = pend_q;
        to_d    = to_q;
        unique case (state_q)
            ST_OFF: begin
                if (pend_q) begin
                    state_d = ST_RAMP;
                    src_d   = SRC_NONE;
                    lin_d   = vbus_raw_i;
                    pend_d  = 1'b0;
                    to_d    = '0;
                end else if (rtc_i) begin
                    state_d = ST_RAMP;
                    src_d   = SRC_RTC;
                    lin_d   = vbus_raw_i;
                    to_d    = '0;
                end else if (psw_raw_i || vbus_raw_i) begin
                    state_d = ST_QUAL;
                end
            end
            ST_QUAL: begin
                if (rtc_i || psw_qual_i || vbus_qual_i) begin
                    state_d = ST_RAMP;
                    lin_d   = vbus_raw_i;
                    to_d    = '0;
                    src_d   = rtc_i ? SRC_RTC : (psw_qual_i ? SRC_PSW : SRC_VBUS);
                end else if (!psw_raw_i && !vbus_raw_i) begin
                    state_d = ST_OFF;
                end
            end
            ST_RAMP: begin
                if (rails_good_i) begin
                    state_d = ST_RUN;
                end else if (trig_lost) begin
                    state_d = ST_OFF;
                end else if (tick_i) begin
                    if (to_q == TO_LAST) begin
                        state_d = ST_OFF;
                    end else begin
                        to_d = to_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (pdn_req_i) begin
                    state_d = ST_DOWN;
                end
            end
            ST_DOWN: begin
                state_d = ST_OFF;
                pend_d  = auto_restart_i;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State and context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            src_q   <= SRC_NONE;
            lin_q   <= 1'b0;
            pend_q  <= 1'b0;
            to_q    <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            lin_q   <= lin_d;
            pend_q  <= pend_d;
            to_q    <= to_d;
        end
    end

    assign state_o = state_q;
    assign src_o   = src_q;
    assign lin_o   = lin_q;

endmodule

// File: rtl/pwr_seq_ctrl.sv
// Power-up sequencer top: qualifies wake levels, synchronizes rail-good,
// runs the sequencer and decodes rail, path, reset and status outputs.
// Assumes tick_i is a one-cycle pulse in the clk domain.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int HOLD_TICKS         = 100,
    parameter int RAMP_TIMEOUT_TICKS = 100,
    parameter int SYNC_STAGES        = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  pswitch_i,
    input  logic                  vbus_ok_i,
    input  logic                  rtc_alarm_i,
    input  logic                  auto_restart_i,
    input  logic                  pwr_down_req_i,
    input  logic [RAIL_COUNT-1:0] rail_good_i,
    output logic [RAIL_COUNT-1:0] rail_en_o,
    output logic                  path_lin_o,
    output logic                  path_dcdc_o,
    output logic                  core_rst_n_o,
    output logic [1:0]            state_o,
    output logic [1:0]            wake_src_o
);
    localparam int N_LEVEL = 2;

    logic [N_LEVEL-1:0]    lvl_raw, lvl_qual;
    logic [RAIL_COUNT-1:0] good_sync;
    seq_state_e            st;
    wake_src_e             src;
    logic                  lin;
    logic                  rails_on;

    assign lvl_raw = {vbus_ok_i, pswitch_i};

    for (genvar i = 0; i < N_LEVEL; i++) begin : g_hold
        pwr_hold_qual #(.HOLD_TICKS(HOLD_TICKS)) i_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(tick_i),
            .in_i  (lvl_raw[i]),
            .qual_o(lvl_qual[i])
        );
    end

    pwr_bit_sync #(.WIDTH(RAIL_COUNT), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (rail_good_i),
        .q_o  (good_sync)
    );

    pwr_seq_fsm #(.RAMP_TIMEOUT_TICKS(RAMP_TIMEOUT_TICKS)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .psw_raw_i     (pswitch_i),
        .vbus_raw_i    (vbus_ok_i),
        .psw_qual_i    (lvl_qual[0]),
        .vbus_qual_i   (lvl_qual[1]),
        .rtc_i         (rtc_alarm_i),
        .rails_good_i  (&good_sync),
        .pdn_req_i     (pwr_down_req_i),
        .auto_restart_i(auto_restart_i),
        .state_o       (st),
        .src_o         (src),
        .lin_o         (lin)
    );

    // Output decode from the registered state.
    always_comb begin
        rails_on     = (st == ST_RAMP) || (st == ST_RUN) || (st == ST_DOWN);
        rail_en_o    = {RAIL_COUNT{rails_on}};
        path_lin_o   = rails_on && lin;
        path_dcdc_o  = rails_on && !lin;
        core_rst_n_o = (st == ST_RUN);
        state_o      = (st == ST_DOWN) ? 2'd3 : st[1:0];
        wake_src_o   = src;
    end

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
// Port-level property checker for the power-up sequencer, bound to the top.
module pwr_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rtc_alarm_i,
    input logic [2:0] rail_good_i,
    input logic [2:0] rail_en_o,
    input logic       path_lin_o,
    input logic       path_dcdc_o,
    input logic       core_rst_n_o,
    input logic [1:0] state_o
);
    AST_RELEASE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n_o) |-> $past(&rail_good_i, 3)); // R6
    AST_RST_BEFORE_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_en_o[0]) |-> !$past(core_rst_n_o)); // R9
    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_en_o[0] |-> (!core_rst_n_o && !path_lin_o && !path_dcdc_o)); // R5
    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en_o[0] |-> ($countones({path_lin_o, path_dcdc_o}) == 1)); // R5
    AST_ALARM_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && rtc_alarm_i) |=> (state_o == 2'd2)); // R4
    AST_RUN_FROM_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && $past(state_o) != 2'd3) |-> ($past(state_o) == 2'd2)); // R12
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rtc_alarm_i (rtc_alarm_i),
    .rail_good_i (rail_good_i),
    .rail_en_o   (rail_en_o),
    .path_lin_o  (path_lin_o),
    .path_dcdc_o (path_dcdc_o),
    .core_rst_n_o(core_rst_n_o),
    .state_o     (state_o)
);

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
    localparam int HOLD = 4;
    localparam int TMO  = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, psw = 1'b0, vbus = 1'b0, rtc = 1'b0;
    logic       autor = 1'b0, pdn = 1'b0;
    logic [2:0] good = 3'b000;
    logic [2:0] rail_en;
    logic       lin, dcdc, crst_n;
    logic [1:0] st, src;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(.HOLD_TICKS(HOLD), .RAMP_TIMEOUT_TICKS(TMO)) i_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .pswitch_i(psw), .vbus_ok_i(vbus),
        .rtc_alarm_i(rtc), .auto_restart_i(autor), .pwr_down_req_i(pdn),
        .rail_good_i(good), .rail_en_o(rail_en), .path_lin_o(lin),
        .path_dcdc_o(dcdc), .core_rst_n_o(crst_n), .state_o(st), .wake_src_o(src)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(1);
            tick = 1'b0; step(1);
        end
    endtask

    // Rail/path/reset snapshot: {rail_en, lin, dcdc, crst_n}
    function automatic int outs();
        return {rail_en, lin, dcdc, crst_n};
    endfunction

    initial begin
        step(3);
        chk("R1 state", st, 0);
        chk("R1 src", src, 0);
        chk("R1 outputs", outs(), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 after release", outs(), 0);

        // R2: power-switch hold sweep; short holds never power up.
        for (int k = 0; k < HOLD; k++) begin
            psw = 1'b1; step(1);
            chk("R12 qualify code", st, 1);
            ticks(k);
            chk("R2 short hold stays qualify", st, 1);
            chk("R2 rails off", rail_en, 0);
            psw = 1'b0; step(1);
            chk("R2 back to off", st, 0);
        end
        psw = 1'b1; step(1); ticks(HOLD);
        chk("R2 full hold ramps", st, 2);
        chk("R2 src switch", src, 1);
        chk("R5 dcdc path", outs(), {3'b111, 1'b0, 1'b1, 1'b0});
        psw = 1'b0; step(1);
        chk("R7 switch loss aborts", st, 0);
        chk("R7 rails off", rail_en, 0);

        // R3: 5 V hold sweep.
        for (int k = 0; k < HOLD; k++) begin
            vbus = 1'b1; step(1); ticks(k);
            chk("R3 short hold stays qualify", st, 1);
            vbus = 1'b0; step(1);
            chk("R3 back to off", st, 0);
        end
        vbus = 1'b1; step(1); ticks(HOLD);
        chk("R3 full hold ramps", st, 2);
        chk("R3 src 5V", src, 2);
        chk("R5 lin path", outs(), {3'b111, 1'b1, 1'b0, 1'b0});
        good = 3'b111; step(2);
        chk("R6 sync delay still ramp", st, 2);
        step(1);
        chk("R6 run", st, 3);
        chk("R6 reset released", crst_n, 1);
        vbus = 1'b0; step(2);
        chk("R7 5V loss ignored in run", st, 3);
        pdn = 1'b1; step(1); pdn = 1'b0;
        chk("R9 reset first", outs(), {3'b111, 1'b1, 1'b0, 1'b0});
        chk("R9 state holds run code", st, 3);
        step(1);
        chk("R9 rails off next", outs(), 0);
        chk("R9 off", st, 0);
        step(3);
        chk("R10 no restart when disabled", st, 0);
        good = 3'b000; step(3);

        // R4: alarm wake and partial rail-good sweep.
        rtc = 1'b1; step(1); rtc = 1'b0;
        chk("R4 alarm ramps at once", st, 2);
        chk("R4 src alarm", src, 3);
        for (int p = 0; p < 7; p++) begin
            good = 3'(p); step(4);
            chk("R6 partial good stays ramp", st, 2);
            chk("R6 partial good reset held", crst_n, 0);
        end
        good = 3'b000; step(3);
        chk("R7 switch low ignored for alarm ramp", st, 2);
        ticks(TMO - 1);
        chk("R8 before timeout", st, 2);
        ticks(1);
        chk("R8 timeout to off", st, 0);

        // R4 in qualify, then R10 auto-restart.
        vbus = 1'b1; step(1);
        chk("R3 qualify on 5V", st, 1);
        rtc = 1'b1; step(1); rtc = 1'b0;
        chk("R4 alarm from qualify", st, 2);
        chk("R4 src alarm from qualify", src, 3);
        chk("R5 lin with 5V", lin, 1);
        good = 3'b111; step(3);
        chk("R6 run via alarm", st, 3);
        vbus = 1'b0; autor = 1'b1; good = 3'b000;
        pdn = 1'b1; step(1); pdn = 1'b0;
        chk("R9 teardown reset", crst_n, 0);
        step(1);
        chk("R10 one off cycle", outs(), 0);
        step(1);
        chk("R10 restart ramp", st, 2);
        chk("R10 restart src", src, 0);
        chk("R10 restart path", outs(), {3'b111, 1'b0, 1'b1, 1'b0});
        ticks(TMO);
        chk("R10 restart timeout off", st, 0);
        step(3);
        chk("R10 no restart after abort", st, 0);
        autor = 1'b0;

        // R11: simultaneous qualification; switch beats 5 V.
        psw = 1'b1; vbus = 1'b1; step(1); ticks(HOLD);
        chk("R11 switch over 5V", src, 1);
        chk("R11 lin path", lin, 1);
        vbus = 1'b0; step(2);
        chk("R7 5V loss ignored for switch ramp", st, 2);
        psw = 1'b0; step(1);
        chk("R7 switch loss off", st, 0);

        // R11: alarm arrives on the cycle the switch qualifies.
        psw = 1'b1; step(1); ticks(HOLD - 1);
        tick = 1'b1; step(1); tick = 1'b0;
        rtc = 1'b1; step(1); rtc = 1'b0;
        chk("R11 alarm over switch", src, 3);
        chk("R11 ramp", st, 2);
        psw = 1'b0; step(2);
        chk("R7 switch loss ignored for alarm", st, 2);
        ticks(TMO);
        chk("R8 timeout off", st, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule